// File: doc/BRIEF.md
# Classified Error Queue with Standard Event Register

This block keeps a first-in first-out record of signed 16-bit error codes (two's complement) and feeds the standard event status register that a status byte summarises. Each code that enters the queue is sorted by numeric band into one of four error categories, and the matching category bit is latched in the event register at the same clock edge. Software-side logic takes codes out one at a time from the oldest end. It can read the count at any time, drain the whole queue by popping repeatedly, or discard everything with a clear strobe.

The oldest entry is always visible on `next_code` without a clock. A pop removes it at the next edge. An empty queue shows code 0, which means no error. When a push meets a full queue, the newest slot is replaced by the overflow code -350, so the loss itself is recorded. The event register latches category bits, a power-on bit and an operation-complete bit. It clears when read, and its masked OR drives the event summary output. `err_avail` drives the error-available bit of the status byte.

Top module: `err_status_queue`

## Requirements
- R1: Codes leave in the order they arrived. `next_code` shows the oldest entry, and a pop removes that entry at the next clock edge.
- R2: `err_count` gives the number of stored entries (0 to DEPTH). A push and a pop in the same cycle on a non-empty queue leave the count unchanged. `err_avail` is high exactly while the count is nonzero, so it drops when the last entry is popped.
- R3: When the queue is empty, `next_code` is 0, and a pop leaves the count at 0.
- R4: A pushed code sets an event bit by range: -184..-100 sets bit 5, -294..-200 sets bit 4, -365..-300 sets bit 3, and -440..-400 sets bit 2.
- R5: A code outside all four ranges is still queued and counted, but it sets no event bit.
- R6: A push into a full queue without a pop writes -350 into the newest slot. The count stays at DEPTH, and only event bit 3 is set.
- R7: Pulsing `esr_read` clears the event register at the next edge. Any event set in that same cycle is kept.
- R8: `esb` is high when any event bit is set whose matching `ese_value` bit is also set. `ese_value` is loaded from `ese_wdata` when `ese_wr` is high.
- R9: Event bit 7 (power-on) is set at the first clock edge after reset is released.
- R10: `clear` empties the queue and clears the event register at the next edge. It takes priority over push, pop and event sets in the same cycle. The enable mask is left unchanged.
- R11: `opc_evt` sets event bit 0 (operation complete).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Empty queue and event register |
| push_valid | input | 1 | Enqueue `push_code` this cycle |
| push_code | input | 16 | Signed error code to store |
| pop_req | input | 1 | Remove the oldest entry |
| next_code | output | 16 | Oldest entry, 0 when empty |
| err_count | output | $clog2(DEPTH+1) (5) | Stored entry count |
| err_avail | output | 1 | Queue non-empty |
| opc_evt | input | 1 | Operation-complete event |
| esr_read | input | 1 | Destructive read of event register |
| esr_value | output | 8 | Event register contents |
| ese_wr | input | 1 | Load enable mask |
| ese_wdata | input | 8 | New enable mask |
| ese_value | output | 8 | Current enable mask |
| esb | output | 1 | Event summary (event AND enable, ORed) |

## Verification
On every cycle, the assertions check the following:
- the count bound;
- that the count holds under a simultaneous push and pop;
- that `err_avail` falls when the last entry leaves;
- that a pop of an empty queue keeps it empty;
- the overflow outcome (full count plus bit 3);
- the command-error band;
- what clear and a quiet destructive read leave behind.

Only the bench's scenarios can show the arrival order across a full drain, the exact position of -350 at the tail after overflow, the out-of-range codes that set nothing, the power-on bit after reset, and the summary tracking a changed mask.

// File: rtl/errq_pkg.sv
package errq_pkg;

  localparam int CODE_W = 16;
  localparam int EV_W   = 8;

  // event register bit positions (decoded by the status byte logic)
  localparam int EV_PON = 7;
  localparam int EV_CMD = 5;
  localparam int EV_EXE = 4;
  localparam int EV_DEV = 3;
  localparam int EV_QRY = 2;
  localparam int EV_OPC = 0;

  localparam int NUM_CLASSES = 4;

  localparam logic signed [CODE_W-1:0] OVF_CODE = -16'sd350;
  localparam logic signed [CODE_W-1:0] NO_ERR   = 16'sd0;

  typedef struct packed {
    logic signed [CODE_W-1:0] lo;
    logic signed [CODE_W-1:0] hi;
    logic [2:0]               bitpos;
  } class_rule_t;

  // Band k spans -(100*(k+1) + span_k) .. -100*(k+1) and maps to bit 5-k.
  function automatic int class_span(input int idx);
    case (idx)
      0:       return 84;
      1:       return 94;
      2:       return 65;
      default: return 40;
    endcase
  endfunction

  function automatic class_rule_t class_rule(input int idx);
    class_rule_t r;
    int top;
    top      = 100 * (idx + 1);
    r.hi     = CODE_W'(-top);
    r.lo     = CODE_W'(-(top + class_span(idx)));
    r.bitpos = 3'(EV_CMD - idx);
    return r;
  endfunction

endpackage

// File: rtl/errq_classify.sv
module errq_classify
  import errq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              accept,
  input  logic              overflow,
  output logic [EV_W-1:0]   hit_bits
);

  logic [NUM_CLASSES-1:0] match;

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_rule
    localparam class_rule_t RULE = class_rule(g);
    assign match[g] = ($signed(code) >= $signed(RULE.lo)) &&
                      ($signed(code) <= $signed(RULE.hi));
  end

  always_comb begin
    hit_bits = '0;
    if (overflow) begin
      hit_bits[EV_DEV] = 1'b1;
    end else if (accept) begin
      for (int i = 0; i < NUM_CLASSES; i++) begin
        if (match[i]) hit_bits[class_rule(i).bitpos] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/errq_fifo.sv
module errq_fifo #(
  parameter  int DEPTH = 16,
  parameter  int W     = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic [W-1:0]     ovf_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             push_fire,
  output logic             pop_fire,
  output logic             ovf_fire
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             full, empty, fresh_slot;
  logic [PTR_W-1:0] wr_idx;
  logic [W-1:0]     wr_data;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  assign full       = (count == CNT_W'(DEPTH));
  assign empty      = (count == '0);
  assign pop_fire   = pop && !empty && !clear;
  assign push_fire  = push && !clear;
  assign ovf_fire   = push_fire && full && !pop_fire;
  assign fresh_slot = push_fire && !ovf_fire;

  assign wr_idx  = ovf_fire ? ptr_prev(wr_ptr) : wr_ptr;
  assign wr_data = ovf_fire ? ovf_data : push_data;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (fresh_slot) wr_ptr <= ptr_next(wr_ptr);
      if (pop_fire)   rd_ptr <= ptr_next(rd_ptr);
      case ({fresh_slot, pop_fire})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/errq_event_reg.sv
module errq_event_reg #(
  parameter int EW      = 8,
  parameter int PON_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [EW-1:0] set_bits,
  input  logic          rd_clr,
  input  logic          en_wr,
  input  logic [EW-1:0] en_wdata,
  output logic [EW-1:0] events,
  output logic [EW-1:0] enables,
  output logic          summary
);

  logic          por_pend;
  logic [EW-1:0] pon_set, all_set, kept;

  assign pon_set = por_pend ? EW'(1) << PON_BIT : '0;
  assign all_set = set_bits | pon_set;
  assign kept    = rd_clr ? '0 : events;
  assign summary = |(events & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_pend <= 1'b1;
      events   <= '0;
    end else begin
      por_pend <= 1'b0;
      events   <= clear ? '0 : (kept | all_set);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enables <= '0;
    else if (en_wr) enables <= en_wdata;
  end

endmodule

// File: rtl/err_status_queue.sv
module err_status_queue
  import errq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push_valid,
  input  logic [CODE_W-1:0] push_code,
  input  logic              pop_req,
  output logic [CODE_W-1:0] next_code,
  output logic [CNT_W-1:0]  err_count,
  output logic              err_avail,
  input  logic              opc_evt,
  input  logic              esr_read,
  output logic [EV_W-1:0]   esr_value,
  input  logic              ese_wr,
  input  logic [EV_W-1:0]   ese_wdata,
  output logic [EV_W-1:0]   ese_value,
  output logic              esb
);

  // named internal events, observed by the bound checker
  logic            push_fire, pop_fire, ovf_fire;
  logic [EV_W-1:0] class_bits, ev_set;

  errq_fifo #(.DEPTH(DEPTH), .W(CODE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .push      (push_valid),
    .push_data (push_code),
    .ovf_data  (OVF_CODE),
    .pop       (pop_req),
    .head      (next_code),
    .count     (err_count),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .ovf_fire  (ovf_fire)
  );

  errq_classify u_class (
    .code     (push_code),
    .accept   (push_fire),
    .overflow (ovf_fire),
    .hit_bits (class_bits)
  );

  assign ev_set = class_bits | (opc_evt ? EV_W'(1) << EV_OPC : '0);

  errq_event_reg #(.EW(EV_W), .PON_BIT(EV_PON)) u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .set_bits (ev_set),
    .rd_clr   (esr_read),
    .en_wr    (ese_wr),
    .en_wdata (ese_wdata),
    .events   (esr_value),
    .enables  (ese_value),
    .summary  (esb)
  );

  assign err_avail = (err_count != '0);

endmodule

// File: rtl/err_status_queue_chk.sv
module err_status_queue_chk #(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             push_valid,
  input logic [15:0]      push_code,
  input logic             pop_req,
  input logic             opc_evt,
  input logic             esr_read,
  input logic [CNT_W-1:0] err_count,
  input logic             err_avail,
  input logic [7:0]       esr_value,
  input logic             push_fire,
  input logic             pop_fire,
  input logic             ovf_fire
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= CNT_W'(DEPTH));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> (err_count == $past(err_count)));

  p_avail_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire && err_count == CNT_W'(1)) |=> !err_avail);

  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && err_count == '0 && !push_valid) |=> (err_count == '0));

  p_cmd_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !ovf_fire && $signed(push_code) >= -16'sd184 &&
     $signed(push_code) <= -16'sd100) |=> esr_value[5]);

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_fire |=> (err_count == CNT_W'(DEPTH) && esr_value[3]));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && esr_read && !push_valid && !opc_evt) |=> (esr_value == 8'h00));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err_count == '0 && esr_value == 8'h00));

endmodule

bind err_status_queue err_status_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .push_valid (push_valid),
  .push_code  (push_code),
  .pop_req    (pop_req),
  .opc_evt    (opc_evt),
  .esr_read   (esr_read),
  .err_count  (err_count),
  .err_avail  (err_avail),
  .esr_value  (esr_value),
  .push_fire  (push_fire),
  .pop_fire   (pop_fire),
  .ovf_fire   (ovf_fire)
);

// File: tb/err_status_queue_test.sv
`timescale 1ns/1ps
module err_status_queue_test;

  localparam int DEPTH = 16;
  localparam int OVF   = -350;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, push_valid = 1'b0, pop_req = 1'b0;
  logic       opc_evt = 1'b0, esr_read = 1'b0, ese_wr = 1'b0;
  logic [15:0] push_code = '0;
  logic [7:0]  ese_wdata = '0;
  logic [15:0] next_code;
  logic [4:0]  err_count;
  logic        err_avail, esb;
  logic [7:0]  esr_value, ese_value;

  int checks = 0;
  int errors = 0;
  int model[$];

  always #5 clk = ~clk;

  err_status_queue uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push_valid(push_valid),
    .push_code(push_code), .pop_req(pop_req), .next_code(next_code),
    .err_count(err_count), .err_avail(err_avail), .opc_evt(opc_evt),
    .esr_read(esr_read), .esr_value(esr_value), .ese_wr(ese_wr),
    .ese_wdata(ese_wdata), .ese_value(ese_value), .esb(esb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // category bit from the requirement table, written by magnitude
  function automatic int band_bit(input int code);
    int m;
    m = -code;
    if (m inside {[100:184]}) return 32;
    if (m inside {[200:294]}) return 16;
    if (m inside {[300:365]}) return 8;
    if (m inside {[400:440]}) return 4;
    return 0;
  endfunction

  // monitor: compares the oldest entry whenever a pop is taken (R1, R3)
  always @(posedge clk) begin
    if (rst_n && pop_req && !clear) begin
      int exp;
      exp = (model.size() == 0) ? 0 : model.pop_front();
      check("R1 pop order", int'($signed(next_code)), exp);
    end
  end

  // driver: one cycle of stimulus, scoreboard updated after the edge
  task automatic drive(input bit p, input int code, input bit q,
                       input bit rd = 1'b0, input bit opc = 1'b0);
    push_valid = p; push_code = code[15:0]; pop_req = q;
    esr_read = rd; opc_evt = opc;
    @(posedge clk); #1;
    if (p) begin
      if (model.size() == DEPTH && !q) model[DEPTH-1] = OVF;
      else model.push_back(code);
    end
    push_valid = 1'b0; pop_req = 1'b0; esr_read = 1'b0; opc_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_mask(input logic [7:0] m);
    ese_wr = 1'b1; ese_wdata = m;
    @(posedge clk); #1;
    ese_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(posedge clk); #1;
    model.delete();
    clear = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int exp_esr;
    int cls_codes[4] = '{-150, -250, -320, -420};
    int odd_codes[4] = '{-185, -99, -441, 123};

    repeat (3) @(negedge clk);
    check("R2 count in reset", int'(err_count), 0);
    check("R2 avail in reset", int'(err_avail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 power-on bit", int'(esr_value), 8'h80);
    check("R3 empty head", int'($signed(next_code)), 0);

    drive(0, 0, 0, 1);
    check("R7 read clears", int'(esr_value), 0);

    exp_esr = 0;
    foreach (cls_codes[i]) begin
      drive(1, cls_codes[i], 0);
      exp_esr |= band_bit(cls_codes[i]);
    end
    check("R4 band bits", int'(esr_value), exp_esr);
    check("R4 band bits value", exp_esr, 8'h3C);
    check("R2 count four", int'(err_count), 4);
    check("R2 avail set", int'(err_avail), 1);

    drive(0, 0, 0, 1);
    foreach (odd_codes[i]) drive(1, odd_codes[i], 0);
    check("R5 no bit for out-of-range", int'(esr_value), 0);
    check("R5 still counted", int'(err_count), 8);

    for (int i = 0; i < 8; i++) drive(0, 0, 1);
    check("R2 drained count", int'(err_count), 0);
    check("R2 avail dropped", int'(err_avail), 0);

    check("R3 empty head zero", int'($signed(next_code)), 0);
    drive(0, 0, 1);
    check("R3 empty pop count", int'(err_count), 0);

    drive(1, -110, 0, 1);
    check("R7 same-cycle event kept", int'(esr_value), 8'h20);

    write_mask(8'h20);
    check("R8 summary on", int'(esb), 1);
    write_mask(8'h10);
    check("R8 mask readback", int'(ese_value), 8'h10);
    check("R8 summary off", int'(esb), 0);

    drive(1, -210, 1);
    check("R2 push+pop count", int'(err_count), 1);

    for (int i = 0; i < DEPTH - 1; i++) drive(1, -201, 0);
    check("R6 full count", int'(err_count), DEPTH);
    drive(0, 0, 0, 1);
    drive(1, -110, 0);
    check("R6 count stays full", int'(err_count), DEPTH);
    check("R6 only bit 3", int'(esr_value), 8'h08);
    for (int i = 0; i < DEPTH - 1; i++) drive(0, 0, 1);
    check("R6 tail holds -350", int'($signed(next_code)), OVF);
    drive(0, 0, 1);
    check("R6 drained", int'(err_count), 0);

    drive(0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);
    check("R11 operation complete", int'(esr_value), 8'h01);

    drive(1, -120, 0);
    drive(1, -230, 0);
    drive(1, 55, 0);
    do_clear();
    check("R10 count cleared", int'(err_count), 0);
    check("R10 events cleared", int'(esr_value), 0);
    check("R10 head zero", int'($signed(next_code)), 0);
    check("R10 mask kept", int'(ese_value), 8'h10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule